// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port Controller

This block moves one byte at a time over a three-wire synchronous serial link, either as the side that makes the clock or as the side that follows it. Transfers are full duplex. A single shift register is used: while the outgoing byte leaves most significant bit first, the incoming bits fill in behind it. When the byte ends, the register holds what was received. Software works through three small registers: control, status and data. Writing the data register starts a transfer when the block makes the clock.

When the block makes the clock, it divides the system clock by 4, 8, 16 or 32 to form the serial clock. When it follows, the external serial clock, the data input and the select input are synchronised and edge-detected, so the external clock may run no faster than a quarter of the system clock. Clock idle level and sampling phase are programmable. Status reports three events: byte complete, a data write refused because a transfer was running, and a select conflict while the block was making the clock. An interrupt line follows the byte-complete flag.

Top module: `spi_port`

## Requirements
- R1: After reset every register reads zero, all three output enables are low, the serial clock output is low and `irq` is low.
- R2: Control register (address 0) fields: bit 0 enable, bit 1 clock-maker (master) select, bit 2 clock idle level, bit 3 phase, bits 5:4 rate, bit 6 interrupt enable. Bit 7 reads as zero. In master mode the serial clock rests at the idle level. A data write (address 2) starts a byte. The clock then toggles 16 times, the first toggle coming H clock cycles after the write edge and each later toggle H cycles after the one before, where H = 2 << rate (dividers 4, 8, 16, 32).
- R3: Master output data is sent most significant bit first. With phase 0, bit 7 is on `mosi_o` from the write and each next bit appears at every even-numbered toggle. With phase 1, each bit appears at the odd-numbered toggle.
- R4: In master mode `miso_i` is sampled on the other toggle of each pair. After the byte, the data register reads the eight received bits, the first received bit in bit 7.
- R5: Status (address 1) bit 7 is set when a byte completes, and `irq` equals that bit ANDed with control bit 6.
- R6: A data write while a byte is in progress sets status bit 6. The shift register is left untouched and the running byte completes with its original data.
- R7: Status flags clear only by a status read that sees a flag set followed by a data register read or write.
- R8: If the synchronised select input is low while enabled in master mode, status bit 4 is set, control bit 1 clears, clock and data output enables drop and the byte is abandoned without setting bit 7.
- R9: In slave mode the block shifts with the external clock in the same four phase/idle combinations: out on `miso_o`, in from `mosi_i`. After 16 edges it sets bit 7 and holds the received byte.
- R10: In slave mode `miso_oe` is high only while select is low. Raising select resets the bit count, so a partial byte sets no flag and a following full byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on flag clearing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data from the master (slave) |
| mosi_o | output | 1 | Serial data to slaves (master) |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data from a slave (master) |
| miso_o | output | 1 | Serial data to the master (slave) |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The bench compares the master clock and data pins against a model on every cycle for all four phase/idle combinations and every rate. A divider off by one, or a phase that drives on the wrong toggle, shows up within the first bit. A write in the middle of a byte must leave the outgoing bits unchanged and raise only the collision flag, which catches a design that reloads the shift register. A select conflict must silence the pins and never report completion. A slave byte cut short by select must not leave a stale bit count that shifts the next byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int unsigned STAT_DONE_BIT = 7;
    localparam int unsigned STAT_WCOL_BIT = 6;
    localparam int unsigned STAT_MODF_BIT = 4;

    typedef struct packed {
        logic       irq_en;
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       enable;
    } ctrl_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int unsigned   W      = 3,
    parameter int unsigned   STAGES = 2,
    parameter logic [W-1:0]  RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
    parameter int unsigned RATE_W    = 2,
    parameter int unsigned BASE_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int unsigned CNT_W = BASE_LOG2 + (1 << RATE_W);

    logic [CNT_W-1:0] cnt_q, cnt_d, limit;

    always_comb begin
        limit = (CNT_W'(1) << (CNT_W'(BASE_LOG2) + CNT_W'(rate))) - CNT_W'(1);
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start,
    input  logic [DW-1:0] load_data,
    input  logic          abort,
    input  logic          edge_ev,
    input  logic          cpha,
    input  logic          din,
    output logic [DW-1:0] sreg,
    output logic          dout,
    output logic          busy,
    output logic          phase,
    output logic          done
);
    localparam int unsigned EDGES = 2 * DW;
    localparam int unsigned EC_W  = $clog2(EDGES);
    localparam logic [EC_W-1:0] LAST = EC_W'(EDGES - 1);

    logic [DW-1:0]   sreg_q, sreg_d;
    logic [EC_W-1:0] ecnt_q, ecnt_d;
    logic            out_q, out_d;
    logic            hold_q, hold_d;
    logic            active_q, active_d;

    always_comb begin
        sreg_d   = sreg_q;
        ecnt_d   = ecnt_q;
        out_d    = out_q;
        hold_d   = hold_q;
        active_d = active_q;
        done     = 1'b0;
        if (load) begin
            sreg_d   = load_data;
            out_d    = load_data[DW-1];
            active_d = start;
            ecnt_d   = '0;
        end else if (edge_ev) begin
            active_d = 1'b1;
            if (!ecnt_q[0]) begin
                if (cpha) out_d  = sreg_q[DW-1];
                else      hold_d = din;
            end else begin
                sreg_d = {sreg_q[DW-2:0], (cpha ? din : hold_q)};
            end
            if (ecnt_q == LAST) begin
                ecnt_d   = '0;
                active_d = 1'b0;
                done     = 1'b1;
            end else begin
                ecnt_d = ecnt_q + EC_W'(1);
            end
        end
        if (abort) begin
            active_d = 1'b0;
            ecnt_d   = '0;
            done     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q   <= '0;
            ecnt_q   <= '0;
            out_q    <= 1'b0;
            hold_q   <= 1'b0;
            active_q <= 1'b0;
        end else begin
            sreg_q   <= sreg_d;
            ecnt_q   <= ecnt_d;
            out_q    <= out_d;
            hold_q   <= hold_d;
            active_q <= active_d;
        end
    end

    assign sreg  = sreg_q;
    assign dout  = cpha ? out_q : sreg_q[DW-1];
    assign busy  = active_q;
    assign phase = ecnt_q[0];

    // R6
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active_q);
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned RATE_W = 2;

    typedef struct packed {
        ctrl_t ctrl;
        logic  done;
        logic  wcol;
        logic  modf;
        logic  arm;
        logic  sck_prev;
    } state_t;

    state_t st_q, st_d;

    logic          ss_s, sck_s, mosi_s;
    logic          is_master, is_slave, fault;
    logic          wr_ctrl, wr_data, rd_stat, data_access;
    logic          busy, phase, xfer_done, dout, tick;
    logic          load, start, abort, edge_ev, slv_edge, din;
    logic [DW-1:0] sreg;
    logic [DW-1:0] stat;
    logic          unused_wbits;

    spi_port_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST    (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ss_n_i, sck_i, mosi_i}),
        .dout  ({ss_s, sck_s, mosi_s})
    );

    assign is_master   = st_q.ctrl.enable && st_q.ctrl.master;
    assign is_slave    = st_q.ctrl.enable && !st_q.ctrl.master;
    assign fault       = is_master && !ss_s;
    assign wr_ctrl     = reg_wr && (reg_addr == REG_CTRL);
    assign wr_data     = reg_wr && (reg_addr == REG_DATA);
    assign rd_stat     = reg_rd && (reg_addr == REG_STAT);
    assign data_access = (reg_wr || reg_rd) && (reg_addr == REG_DATA);

    assign slv_edge = is_slave && !ss_s && (sck_s != st_q.sck_prev);
    assign edge_ev  = is_master ? tick : slv_edge;
    assign load     = wr_data && !busy;
    assign start    = is_master && !fault;
    assign abort    = fault || !st_q.ctrl.enable || (is_slave && ss_s);
    assign din      = is_master ? miso_i : mosi_s;

    spi_port_clkgen #(
        .RATE_W    (RATE_W),
        .BASE_LOG2 (1)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (is_master && busy),
        .rate  (st_q.ctrl.rate),
        .tick  (tick)
    );

    spi_port_shifter #(
        .DW (DW)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .start     (start),
        .load_data (reg_wdata),
        .abort     (abort),
        .edge_ev   (edge_ev),
        .cpha      (st_q.ctrl.cpha),
        .din       (din),
        .sreg      (sreg),
        .dout      (dout),
        .busy      (busy),
        .phase     (phase),
        .done      (xfer_done)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (data_access && st_q.arm) begin
            st_d.done = 1'b0;
            st_d.wcol = 1'b0;
            st_d.modf = 1'b0;
            st_d.arm  = 1'b0;
        end
        if (rd_stat && (st_q.done || st_q.wcol || st_q.modf)) st_d.arm = 1'b1;
        if (xfer_done)        st_d.done = 1'b1;
        if (wr_data && busy)  st_d.wcol = 1'b1;
        if (fault) begin
            st_d.modf        = 1'b1;
            st_d.ctrl.master = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat                = '0;
        stat[STAT_DONE_BIT] = st_q.done;
        stat[STAT_WCOL_BIT] = st_q.wcol;
        stat[STAT_MODF_BIT] = st_q.modf;
        case (reg_addr)
            REG_CTRL: reg_rdata = DW'(st_q.ctrl);
            REG_STAT: reg_rdata = stat;
            REG_DATA: reg_rdata = sreg;
            default:  reg_rdata = '0;
        endcase
    end

    assign unused_wbits = ^reg_wdata[DW-1:CTRL_W];

    assign irq     = st_q.done && st_q.ctrl.irq_en;
    assign sck_o   = st_q.ctrl.cpol ^ (is_master && phase);
    assign sck_oe  = is_master;
    assign mosi_o  = dout;
    assign mosi_oe = is_master;
    assign miso_o  = dout;
    assign miso_oe = is_slave && !ss_s;

    // R6
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> st_q.wcol);

    // R8
    modf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.modf) |-> (!st_q.ctrl.master && !busy));

    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> !busy);

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !busy) |-> (sck_o == st_q.ctrl.cpol));
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    int         nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Master byte against a per-cycle pin model
    task automatic master_xfer(input logic [1:0] rate, input logic cpol, input logic cpha,
                               input logic [7:0] tx, input logic [7:0] rx, input logic collide);
        int h = 2 << rate;
        logic [7:0] v;
        wr(2'd0, {1'b0, 1'b1, rate, cpha, cpol, 2'b11});
        chk("R2 idle sck", sck_o, cpol);
        @(negedge clk);
        miso_i = rx[7]; reg_addr = 2'd2; reg_wdata = tx; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R3 first mosi", mosi_o, tx[7]);
        for (int t = 1; t <= 16 * h; t++) begin
            int k, idx;
            @(negedge clk);
            reg_wr = 1'b0;
            k = t / h;
            if (k < 16) begin
                idx = cpha ? ((k == 0) ? 0 : (k - 1) / 2) : k / 2;
                chk("R2 sck level", sck_o, cpol ^ k[0]);
                chk("R3 mosi bit", mosi_o, tx[7 - idx]);
                miso_i = rx[7 - idx];
            end
            if (collide && t == 5) begin
                reg_addr = 2'd2; reg_wdata = ~tx; reg_wr = 1'b1;
            end
        end
        chk("R2 sck back idle", sck_o, cpol);
        chk("R5 irq on done", irq, 1);
        rd(2'd1, v);
        chk(collide ? "R6 status collision" : "R5 status done", v, collide ? 8'hC0 : 8'h80);
        rd(2'd2, v);
        chk("R4 received byte", v, rx);
        rd(2'd1, v);
        chk("R7 flags cleared", v, 0);
        chk("R5 irq cleared", irq, 0);
    endtask

    task automatic slave_bits(input logic cpol, input logic cpha, input logic [7:0] stx,
                              input logic [7:0] mtx, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi_i = mtx[7 - i];
                ticks(8);
                chk("R9 miso bit", miso_o, stx[7 - i]);
                sck_i = ~cpol; ticks(8);
                sck_i = cpol;  ticks(8);
            end else begin
                sck_i = ~cpol; ticks(4);
                mosi_i = mtx[7 - i]; ticks(4);
                chk("R9 miso bit", miso_o, stx[7 - i]);
                sck_i = cpol;  ticks(8);
            end
        end
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] stx, input logic [7:0] mtx, input logic partial);
        logic [7:0] v;
        wr(2'd0, {1'b0, 1'b0, 2'b00, cpha, cpol, 1'b0, 1'b1});
        sck_i = cpol; ticks(4);
        wr(2'd2, stx);
        chk("R10 miso off while deselected", miso_oe, 0);
        if (partial) begin
            ss_n_i = 1'b0; ticks(4);
            slave_bits(cpol, cpha, 8'h00, 8'hFF, 0);
            slave_bits(cpol, cpha, stx, mtx, 3);
            ss_n_i = 1'b1; ticks(6);
            rd(2'd1, v);
            chk("R10 partial byte sets no flag", v, 0);
            wr(2'd2, stx);
            rd(2'd1, v);
            chk("R10 reload after deselect is no collision", v, 0);
        end
        ss_n_i = 1'b0; ticks(4);
        chk("R10 miso on while selected", miso_oe, 1);
        slave_bits(cpol, cpha, stx, mtx, 8);
        ticks(8);
        rd(2'd1, v);
        chk("R9 slave done", v, 8'h80);
        chk("R5 irq masked", irq, 0);
        rd(2'd2, v);
        chk("R9 slave received", v, mtx);
        ss_n_i = 1'b1; ticks(4);
        chk("R10 miso off after deselect", miso_oe, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        // R1
        rd(2'd0, v); chk("R1 ctrl reset", v, 0);
        rd(2'd1, v); chk("R1 status reset", v, 0);
        rd(2'd2, v); chk("R1 data reset", v, 0);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 mosi_oe", mosi_oe, 0);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 sck_o", sck_o, 0);
        chk("R1 irq", irq, 0);
        // R2 field layout read back, bit 7 reads zero
        wr(2'd0, 8'hEC);
        rd(2'd0, v); chk("R2 ctrl readback", v, 8'h6C);
        wr(2'd0, 8'h00);

        master_xfer(2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
        master_xfer(2'd1, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b0);
        master_xfer(2'd2, 1'b0, 1'b1, 8'h4B, 8'hD2, 1'b0);
        master_xfer(2'd3, 1'b1, 1'b1, 8'hF0, 8'h0F, 1'b0);
        // R6 collision mid-byte
        master_xfer(2'd0, 1'b0, 1'b1, 8'h96, 8'h59, 1'b1);

        // R8 mode fault
        wr(2'd0, 8'h73);
        chk("R8 outputs enabled as master", sck_oe, 1);
        wr(2'd2, 8'h5A);
        ticks(20);
        ss_n_i = 1'b0;
        ticks(5);
        chk("R8 sck_oe dropped", sck_oe, 0);
        chk("R8 mosi_oe dropped", mosi_oe, 0);
        rd(2'd0, v); chk("R8 master bit cleared", v, 8'h71);
        ticks(600);
        chk("R8 no completion irq", irq, 0);
        rd(2'd1, v); chk("R8 fault flag only", v, 8'h10);
        rd(2'd2, v);
        rd(2'd1, v); chk("R7 fault flag cleared", v, 0);
        ss_n_i = 1'b1;
        ticks(4);

        slave_xfer(1'b0, 1'b0, 8'hC3, 8'h5A, 1'b0);
        slave_xfer(1'b1, 1'b1, 8'h2D, 8'hB4, 1'b0);
        slave_xfer(1'b0, 1'b1, 8'h69, 8'h1E, 1'b1);
        slave_xfer(1'b1, 1'b0, 8'h87, 8'hE1, 1'b1);

        summary();
        $finish;
    end
endmodule